// File: doc/BRIEF.md
# Single-Bus Accumulator Machine

This block is a compact 8-bit processor in which every register transfer crosses one shared data bus. A program counter, an accumulator, an operand buffer that feeds the ALU, a memory address register, an instruction register, a small constant source, an input port and a 256-word RAM all sit on that bus. A control sequencer fetches each instruction and then runs its execute steps. In every step it enables at most one bus driver and any number of loaders.

The ALU combines the bus value (operand A) with the operand buffer (operand B), and its result is the only thing the accumulator loads. A zero detector on the accumulator decides conditional jumps. The RAM holds a program and data image, set by a parameter, that is restored on every reset. The environment supplies a byte on the input port. It watches the accumulator and a halt flag that rises when the program executes its stop opcode.

An instruction is one opcode word, sometimes followed by one operand word. The fetch takes two steps. In the first, the PC drives the bus and the address register loads. In the second, memory drives the bus into the instruction register and the PC increments.

Top module: `acc_machine`

## Requirements
- R1: While `rst_n` is low, `acc_out` is 0 and `halt` is 0, and RAM holds the preload image. After `rst_n` rises, the core leaves reset on the second rising clock edge and starts fetching at address 0.
- R2: Every instruction starts with a two-step fetch. The step count, including the fetch, is fixed per opcode: 3 for HLT, INV, IN, CON and undefined opcodes; 4 for LDI, JZ and JMP; 5 for LDA and STA; 6 for ADD, SUB and XOR; 7 for LDX. A result loads into the accumulator at the end of the last step, except for LDX (see R9).
- R3: In every step at most one of these drives the bus: PC, accumulator, memory, constant source, input port.
- R4: LDI (0x01, operand n) loads n. LDA (0x02, operand a) loads mem[a]. IN (0x0A) loads the input port. CON k (0x10+k) loads the constant 0x00, 0x01, 0x02 or 0xFF for k = 0, 1, 2, 3.
- R5: STA (0x03, operand a) writes the accumulator to mem[a]. A later LDA of that address returns the stored value.
- R6: ADD (0x04), SUB (0x05) and XOR (0x06), each with operand a, replace the accumulator with acc+mem[a], acc−mem[a] and acc^mem[a], all modulo 256.
- R7: INV (0x07) replaces the accumulator with its bitwise complement.
- R8: JZ (0x08, operand a) jumps to a when the accumulator is zero and otherwise continues after the operand word. JMP (0x0B, operand a) always jumps to a.
- R9: LDX (0x09, operand d) first sets the accumulator to acc+d at the end of step 5 and holds that value for two steps. At the end of step 7 it loads mem[(acc+d) mod 256].
- R10: HLT (0x00) raises `halt` at the end of its third step. From then on `halt` stays high, the accumulator and memory stay unchanged, and no bus driver is enabled.
- R11: Any opcode not listed above (0x0C–0x0F, 0x14–0xFF) does nothing except advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchroniser |
| port_in | input | 8 | Byte the IN instruction places on the bus |
| acc_out | output | 8 | Current accumulator value |
| halt | output | 1 | High once the machine has stopped |

## Verification
On every cycle the assertions check the bus discipline: only one driver at a time, stores taking their data from the accumulator, and jumps loading the PC from memory. They also check that the fetch order is kept and that nothing moves after a halt. Only the bench's runs can show the data results: the arithmetic values, zero-dependent branch direction, displacement addresses that wrap past 0xFF, round trips through stored memory, and the exact step in which each accumulator change appears. The bench covers these by running one program under several input-port values, each selecting different paths and boundary values.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_XOR  = 3'd3,
    ALU_INV  = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    oe_pc;
    logic    inc_pc;
    logic    ld_pc;
    logic    oe_acc;
    logic    ld_acc;
    logic    oe_mem;
    logic    we_mem;
    logic    oe_const;
    logic [1:0] const_sel;
    logic    oe_port;
    logic    ld_abr;
    logic    ld_mar;
    logic    ld_ir;
    alu_op_e alu_op;
  } ctrl_t;

  localparam logic [7:0] OP_HLT = 8'h00;
  localparam logic [7:0] OP_LDI = 8'h01;
  localparam logic [7:0] OP_LDA = 8'h02;
  localparam logic [7:0] OP_STA = 8'h03;
  localparam logic [7:0] OP_ADD = 8'h04;
  localparam logic [7:0] OP_SUB = 8'h05;
  localparam logic [7:0] OP_XOR = 8'h06;
  localparam logic [7:0] OP_INV = 8'h07;
  localparam logic [7:0] OP_JZ  = 8'h08;
  localparam logic [7:0] OP_LDX = 8'h09;
  localparam logic [7:0] OP_IN  = 8'h0A;
  localparam logic [7:0] OP_JMP = 8'h0B;
  localparam logic [5:0] OP_CON_HI = 6'b000100;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] bus_a,
  input  logic [DATA_W-1:0] buf_b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (op)
      ALU_ADD: result = bus_a + buf_b;
      ALU_SUB: result = bus_a - buf_b;
      ALU_XOR: result = bus_a ^ buf_b;
      ALU_INV: result = ~bus_a;
      default: result = bus_a;
    endcase
  end

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= IMAGE[i*DATA_W +: DATA_W];
      end
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opcode,
  input  logic       acc_zero,
  output ctrl_t      ctl,
  output logic       halted
);

  typedef enum logic [1:0] {
    ST_FETCH_A = 2'd0,
    ST_FETCH_B = 2'd1,
    ST_EXEC    = 2'd2,
    ST_STOP    = 2'd3
  } seq_state_e;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              last_step;
  logic              go_stop;

  // operand word fetch shared by all two-word instructions
  function automatic ctrl_t operand_addr(input ctrl_t c);
    ctrl_t r;
    r = c;
    r.oe_pc  = 1'b1;
    r.ld_mar = 1'b1;
    return r;
  endfunction

  always_comb begin
    ctl       = '0;
    ctl.alu_op = ALU_PASS;
    last_step = 1'b0;
    go_stop   = 1'b0;
    state_d   = state_q;
    step_d    = step_q;

    unique case (state_q)
      ST_FETCH_A: begin
        ctl.oe_pc  = 1'b1;
        ctl.ld_mar = 1'b1;
        state_d    = ST_FETCH_B;
      end

      ST_FETCH_B: begin
        ctl.oe_mem = 1'b1;
        ctl.ld_ir  = 1'b1;
        ctl.inc_pc = 1'b1;
        state_d    = ST_EXEC;
        step_d     = '0;
      end

      ST_EXEC: begin
        if (opcode[7:2] == OP_CON_HI) begin
          ctl.oe_const  = 1'b1;
          ctl.const_sel = opcode[1:0];
          ctl.ld_acc    = 1'b1;
          last_step     = 1'b1;
        end else begin
          unique case (opcode)
            OP_HLT: go_stop = 1'b1;

            OP_LDI: begin
              if (step_q == 0) ctl = operand_addr(ctl);
              else begin
                ctl.oe_mem = 1'b1;
                ctl.ld_acc = 1'b1;
                ctl.inc_pc = 1'b1;
                last_step  = 1'b1;
              end
            end

            OP_LDA, OP_STA: begin
              if (step_q == 0) ctl = operand_addr(ctl);
              else if (step_q == 1) begin
                ctl.oe_mem = 1'b1;
                ctl.ld_mar = 1'b1;
                ctl.inc_pc = 1'b1;
              end else begin
                last_step = 1'b1;
                if (opcode == OP_LDA) begin
                  ctl.oe_mem = 1'b1;
                  ctl.ld_acc = 1'b1;
                end else begin
                  ctl.oe_acc = 1'b1;
                  ctl.we_mem = 1'b1;
                end
              end
            end

            OP_ADD, OP_SUB, OP_XOR: begin
              if (step_q == 0) ctl = operand_addr(ctl);
              else if (step_q == 1) begin
                ctl.oe_mem = 1'b1;
                ctl.ld_mar = 1'b1;
                ctl.inc_pc = 1'b1;
              end else if (step_q == 2) begin
                ctl.oe_mem = 1'b1;
                ctl.ld_abr = 1'b1;
              end else begin
                ctl.oe_acc = 1'b1;
                ctl.ld_acc = 1'b1;
                last_step  = 1'b1;
                unique case (opcode)
                  OP_ADD:  ctl.alu_op = ALU_ADD;
                  OP_SUB:  ctl.alu_op = ALU_SUB;
                  default: ctl.alu_op = ALU_XOR;
                endcase
              end
            end

            OP_INV: begin
              ctl.oe_acc = 1'b1;
              ctl.ld_acc = 1'b1;
              ctl.alu_op = ALU_INV;
              last_step  = 1'b1;
            end

            OP_JZ, OP_JMP: begin
              if (step_q == 0) ctl = operand_addr(ctl);
              else begin
                last_step = 1'b1;
                if (opcode == OP_JMP || acc_zero) begin
                  ctl.oe_mem = 1'b1;
                  ctl.ld_pc  = 1'b1;
                end else begin
                  ctl.inc_pc = 1'b1;
                end
              end
            end

            OP_LDX: begin
              unique case (step_q)
                3'd0: ctl = operand_addr(ctl);
                3'd1: begin
                  ctl.oe_mem = 1'b1;
                  ctl.ld_abr = 1'b1;
                  ctl.inc_pc = 1'b1;
                end
                3'd2: begin
                  ctl.oe_acc = 1'b1;
                  ctl.ld_acc = 1'b1;
                  ctl.alu_op = ALU_ADD;
                end
                3'd3: begin
                  ctl.oe_acc = 1'b1;
                  ctl.ld_mar = 1'b1;
                end
                default: begin
                  ctl.oe_mem = 1'b1;
                  ctl.ld_acc = 1'b1;
                  last_step  = 1'b1;
                end
              endcase
            end

            OP_IN: begin
              ctl.oe_port = 1'b1;
              ctl.ld_acc  = 1'b1;
              last_step   = 1'b1;
            end

            default: last_step = 1'b1;
          endcase
        end

        if (go_stop) state_d = ST_STOP;
        else if (last_step) state_d = ST_FETCH_A;
        else step_d = step_q + 1'b1;
      end

      default: ; // ST_STOP: all controls held off
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH_A;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign halted = (state_q == ST_STOP);

endmodule

// File: rtl/acc_machine.sv
module acc_machine
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              halt
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SYNC_W = 2;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_W-1:0] rst_sync_q;
  logic              core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_W-1];

  ctrl_t             ctl;
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] pc_q, acc_q, abr_q, ir_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mem_rdata, alu_res, const_val;
  logic              acc_zero;

  // constant source: 0, 1, 2, all ones
  always_comb begin
    if (ctl.const_sel == 2'd3) const_val = '1;
    else                       const_val = DATA_W'(ctl.const_sel);
  end

  // shared bus: AND-OR of the enabled driver
  always_comb begin
    bus = '0;
    if (ctl.oe_pc)    bus = bus | pc_q;
    if (ctl.oe_acc)   bus = bus | acc_q;
    if (ctl.oe_mem)   bus = bus | mem_rdata;
    if (ctl.oe_const) bus = bus | const_val;
    if (ctl.oe_port)  bus = bus | port_in;
  end

  assign acc_zero = (acc_q == '0);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else if (ctl.ld_pc) begin
      pc_q <= bus;
    end else if (ctl.inc_pc) begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) acc_q <= '0;
    else if (ctl.ld_acc) acc_q <= alu_res;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) abr_q <= '0;
    else if (ctl.ld_abr) abr_q <= bus;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) mar_q <= '0;
    else if (ctl.ld_mar) mar_q <= bus[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ir_q <= '0;
    else if (ctl.ld_ir) ir_q <= bus;
  end

  acc_sequencer u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .opcode   (ir_q[7:0]),
    .acc_zero (acc_zero),
    .ctl      (ctl),
    .halted   (halt)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .bus_a  (bus),
    .buf_b  (abr_q),
    .op     (ctl.alu_op),
    .result (alu_res)
  );

  acc_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .IMAGE  (IMAGE)
  ) u_ram (
    .clk   (clk),
    .rst_n (core_rst_n),
    .addr  (mar_q),
    .we    (ctl.we_mem),
    .wdata (bus),
    .rdata (mem_rdata)
  );

  assign acc_out = acc_q;

endmodule

// File: rtl/acc_machine_chk.sv
module acc_machine_chk
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              core_rst_n,
  input ctrl_t             ctl,
  input logic              halted,
  input logic [DATA_W-1:0] acc
);

  // R3
  single_driver_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({ctl.oe_pc, ctl.oe_acc, ctl.oe_mem, ctl.oe_const, ctl.oe_port}));

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.ld_ir |-> ($past(ctl.oe_pc) && $past(ctl.ld_mar) && ctl.oe_mem));

  // R5
  store_source_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.we_mem |-> (ctl.oe_acc && !ctl.ld_mar));

  // R8
  jump_source_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.ld_pc |-> (ctl.oe_mem && !ctl.inc_pc));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && $stable(acc)));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |-> (!ctl.we_mem && !ctl.ld_acc && !ctl.ld_pc && !ctl.inc_pc &&
                $countones({ctl.oe_pc, ctl.oe_acc, ctl.oe_mem, ctl.oe_const, ctl.oe_port}) == 0));

endmodule

bind acc_machine acc_machine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .ctl        (ctl),
  .halted     (halt),
  .acc        (acc_q)
);

// File: tb/tb_acc_machine.sv
module tb_acc_machine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  function automatic logic [DEPTH*8-1:0] build_image();
    logic [7:0] m [DEPTH];
    logic [DEPTH*8-1:0] img;
    for (int i = 0; i < DEPTH; i++) m[i] = 8'h00;
    m[8'h00] = 8'h0A;                    // IN
    m[8'h01] = 8'h03; m[8'h02] = 8'h80;  // STA 80
    m[8'h03] = 8'h11;                    // CON 1
    m[8'h04] = 8'h04; m[8'h05] = 8'h80;  // ADD 80
    m[8'h06] = 8'h05; m[8'h07] = 8'h90;  // SUB 90
    m[8'h08] = 8'h06; m[8'h09] = 8'h91;  // XOR 91
    m[8'h0A] = 8'h07;                    // INV
    m[8'h0B] = 8'h03; m[8'h0C] = 8'h81;  // STA 81
    m[8'h0D] = 8'h02; m[8'h0E] = 8'h80;  // LDA 80
    m[8'h0F] = 8'h08; m[8'h10] = 8'h20;  // JZ 20
    m[8'h11] = 8'h13;                    // CON 3
    m[8'h12] = 8'h09; m[8'h13] = 8'h01;  // LDX 1 (wraps to 00)
    m[8'h14] = 8'h0B; m[8'h15] = 8'h30;  // JMP 30
    m[8'h20] = 8'h12;                    // CON 2
    m[8'h21] = 8'h09; m[8'h22] = 8'hA0;  // LDX A0
    m[8'h23] = 8'h00;                    // HLT
    m[8'h30] = 8'h01; m[8'h31] = 8'hC3;  // LDI C3
    m[8'h32] = 8'h02; m[8'h33] = 8'h81;  // LDA 81
    m[8'h34] = 8'h0F;                    // undefined
    m[8'h35] = 8'h10;                    // CON 0
    m[8'h36] = 8'h00;                    // HLT
    m[8'h90] = 8'h03;
    m[8'h91] = 8'h5A;
    m[8'hA2] = 8'h77;
    for (int i = 0; i < DEPTH; i++) img[i*8 +: 8] = m[i];
    return img;
  endfunction

  localparam logic [DEPTH*8-1:0] IMG = build_image();

  logic       clk;
  logic       rst_n;
  logic [7:0] port_in;
  logic [7:0] acc_out;
  logic       halt;

  acc_machine #(.DATA_W(8), .DEPTH(DEPTH), .IMAGE(IMG)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_in (port_in),
    .acc_out (acc_out),
    .halt    (halt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] acc;
    logic       hlt;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_pc, m_acc, m_port;
  bit         m_halt;

  task automatic check(input logic [7:0] ea, input logic eh, input string tag);
    checks++;
    if (acc_out !== ea || halt !== eh) begin
      errors++;
      $display("FAIL %s: acc=%h halt=%b expected acc=%h halt=%b", tag, acc_out, halt, ea, eh);
    end
  endtask

  task automatic push(input int k, input logic [7:0] a, input logic h, input string t);
    exp_t e;
    e.acc = a; e.hlt = h; e.tag = t;
    repeat (k) q.push_back(e);
  endtask

  // one instruction of the reference model; one queue entry per clock
  task automatic model_instr();
    logic [7:0] op, opd, s;
    op  = m_mem[m_pc];
    opd = m_mem[8'(m_pc + 8'd1)];
    if (op[7:2] == 6'b000100) begin
      m_pc = m_pc + 8'd1;
      push(2, m_acc, 0, "R2 R4");
      m_acc = (op[1:0] == 2'd3) ? 8'hFF : {6'd0, op[1:0]};
      push(1, m_acc, 0, "R4 con");
    end else begin
      case (op)
        8'h00: begin
          push(2, m_acc, 0, "R2 R10");
          push(1, m_acc, 1, "R10 halt");
          m_halt = 1;
        end
        8'h01: begin
          m_pc += 8'd2; push(3, m_acc, 0, "R2 R4");
          m_acc = opd; push(1, m_acc, 0, "R4 ldi");
        end
        8'h02: begin
          m_pc += 8'd2; push(4, m_acc, 0, "R2 R4");
          m_acc = m_mem[opd]; push(1, m_acc, 0, "R4 R5 lda");
        end
        8'h03: begin
          m_pc += 8'd2; m_mem[opd] = m_acc;
          push(5, m_acc, 0, "R2 R5 sta");
        end
        8'h04, 8'h05, 8'h06: begin
          m_pc += 8'd2; push(5, m_acc, 0, "R2 R6");
          case (op)
            8'h04:   m_acc = m_acc + m_mem[opd];
            8'h05:   m_acc = m_acc - m_mem[opd];
            default: m_acc = m_acc ^ m_mem[opd];
          endcase
          push(1, m_acc, 0, "R6 R3 alu");
        end
        8'h07: begin
          m_pc += 8'd1; push(2, m_acc, 0, "R2 R7");
          m_acc = ~m_acc; push(1, m_acc, 0, "R7 inv");
        end
        8'h08: begin
          m_pc = (m_acc == 8'd0) ? opd : m_pc + 8'd2;
          push(4, m_acc, 0, "R8 jz");
        end
        8'h09: begin
          m_pc += 8'd2; push(4, m_acc, 0, "R2 R9");
          s = m_acc + opd; push(2, s, 0, "R9 sum");
          m_acc = m_mem[s]; push(1, m_acc, 0, "R9 load");
        end
        8'h0A: begin
          m_pc += 8'd1; push(2, m_acc, 0, "R2 R4");
          m_acc = m_port; push(1, m_acc, 0, "R4 in");
        end
        8'h0B: begin
          m_pc = opd; push(4, m_acc, 0, "R8 jmp");
        end
        default: begin
          m_pc += 8'd1; push(3, m_acc, 0, "R11 nop");
        end
      endcase
    end
  endtask

  task automatic run_program(input logic [7:0] p);
    exp_t e;
    int   hc;
    @(negedge clk);
    rst_n   = 1'b0;
    port_in = p;
    repeat (2) @(negedge clk);
    check(8'h00, 1'b0, "R1 reset");
    q.delete();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = IMG[i*8 +: 8];
    m_pc = 0; m_acc = 0; m_halt = 0; m_port = p;
    push(2, 8'h00, 0, "R1 release");
    rst_n = 1'b1;
    hc = 0;
    for (int c = 0; c < 400 && hc < 6; c++) begin
      @(negedge clk);
      if (q.size() == 0) begin
        if (m_halt) push(1, m_acc, 1, "R10 held");
        else        model_instr();
      end
      e = q.pop_front();
      check(e.acc, e.hlt, e.tag);
      if (e.hlt) hc++;
    end
    if (hc < 6) begin
      errors++;
      $display("FAIL R10: halt count %0d expected 6", hc);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    port_in = 8'h00;
    run_program(8'h00);  // zero: JZ taken path
    run_program(8'h05);
    run_program(8'h02);  // SUB result zero
    run_program(8'h80);
    run_program(8'hFF);  // ADD wraps
    run_program(8'h01);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule